// File: doc/BRIEF.md
# Element Condition Test and Truncation Unit

This unit sits after the arithmetic of a vector pipeline and post-processes one element result per cycle. For each element it narrows the wide result to the destination element width, either wrapping or saturating it. It then forms a 4-bit condition field from a signed compare of the narrowed value against zero, and evaluates a single-bit condition test on that field. A two-bit mode input chooses what the test does. In plain and saturate modes the test is ignored. In predicated-result mode a failing test cancels the result store. In fail-on-first mode a failing test, or a memory fault in the load/store variant, cuts the vector length short.

A vector operation begins with a one-cycle `opStart` pulse. The configuration inputs are held steady for the whole operation, and elements then stream in with their index, width code, wide value, predicate bit, fault flag and last-element flag. The unit returns registered write enables for the element result and for its condition field, the field index to write, and, once the operation ends, a done strobe with the final vector length. After an operation ends, further elements are ignored until the next `opStart`.

Top module: `elem_cond_trunc`

## Requirements
- R1: In plain mode (`cfgMode`=00), an enabled element (`elemMask`=1) writes its value truncated to the destination width. The width code `elemWidth` gives 01=8, 10=16, 11=32 and 00=`DATA_W` bits, and the upper bits of `resData` are zero.
- R2: A masked-out element (`elemMask`=0) writes nothing when `cfgZero`=0. With `cfgZero`=1 it writes a result of zero. It never writes a condition field.
- R3: The condition field has bit 3=LT, bit 2=GT and bit 1=EQ, taken from a signed compare of the written value at the destination width against zero, so exactly one of them is set. Bit 0 is the overflow bit and is 0 outside saturate mode. The field is written only when `cfgRec`=1 and the element is enabled.
- R4: With `cfgDestVec`=1 the field index is 8 plus the element index. With a scalar destination it is 0 for an integer result and 1 for an FP result (`cfgDestFp`=1).
- R5: In saturate mode (`cfgMode`=10) with `cfgSatSigned`=0, the wide signed value is clamped to 0 .. 2^w-1.
- R6: In saturate mode with `cfgSatSigned`=1, the value is clamped to -2^(w-1) .. 2^(w-1)-1. Bit 0 of the condition field is 1 exactly when clamping happened.
- R7: The test takes the field bit picked by `cfgCrSel` (0=LT, 1=GT, 2=EQ, 3=overflow). It passes when that bit differs from `cfgCrInv`.
- R8: In predicated-result mode (`cfgMode`=11), an enabled element's condition field is written even when the test fails. A failing element's result is not written, or is written as zero when `cfgZero`=1.
- R9: In condition-driven fail-on-first (`cfgMode`=01, `cfgLdst`=0), the first enabled element whose test fails writes nothing. `done` rises with `vlOut` equal to that element's index, which may be 0.
- R10: In load/store fail-on-first (`cfgLdst`=1) the test is not applied. A fault on element 0 raises `trap` and `done` with `vlOut`=`cfgVl`. A fault on a later element writes nothing and ends the operation with `vlOut` equal to its index.
- R11: After `done`, every element is ignored (no writes and no further `done`) until `opStart`.
- R12: An operation that reaches the element flagged `elemLast` without stopping raises `done` with `vlOut`=`cfgVl`.
- R13: Every output is registered: it is due one clock edge after the element is sampled, and each strobe lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rstN | input | 1 | active-low synchronous reset |
| opStart | input | 1 | begins a vector operation and clears the stopped state |
| cfgMode | input | 2 | 00 plain, 01 fail-on-first, 10 saturate, 11 predicated result |
| cfgZero | input | 1 | zeroing for masked-out or failed elements |
| cfgRec | input | 1 | record flag: write condition fields |
| cfgSatSigned | input | 1 | signed saturation when 1 |
| cfgCrSel | input | 2 | condition bit picked by the test |
| cfgCrInv | input | 1 | invert flag of the test |
| cfgLdst | input | 1 | fail-on-first uses the fault flag instead of the test |
| cfgDestVec | input | 1 | destination is a vector |
| cfgDestFp | input | 1 | scalar destination is floating point |
| cfgVl | input | IDX_W+1 | vector length of the operation |
| elemValid | input | 1 | element present this cycle |
| elemIdx | input | IDX_W | element index |
| elemWidth | input | 2 | destination width code |
| elemResult | input | 2*DATA_W | wide signed result |
| elemMask | input | 1 | predicate bit of the element |
| elemFault | input | 1 | memory fault on this element |
| elemLast | input | 1 | final element of the operation |
| resWe | output | 1 | result write enable |
| resIdx | output | IDX_W | index of the written element |
| resData | output | DATA_W | narrowed result |
| crWe | output | 1 | condition field write enable |
| crIdx | output | IDX_W+1 | condition field index |
| crData | output | 4 | condition field |
| done | output | 1 | operation ended this cycle |
| trap | output | 1 | fault on element 0 reported |
| vlOut | output | IDX_W+1 | final vector length, valid from done |

## Verification
Every result of this unit, including data, field, index, `done`, `trap` and the truncated length, is due one rising edge after the element is sampled. The bench changes inputs on a falling edge and reads outputs on the next falling edge, so each check sits exactly one edge after its stimulus. It drops `elemValid` in the same half-cycle, which also shows that the write strobes last a single cycle. Operations that stop early send one more element after `done` and look for silence on the following falling edge.

// File: rtl/ect_pkg.sv
package ect_pkg;
  typedef enum logic [1:0] {
    MODE_PLAIN  = 2'b00,
    MODE_FFIRST = 2'b01,
    MODE_SAT    = 2'b10,
    MODE_PRED   = 2'b11
  } ectMode_e;

  // control -> datapath strobes
  typedef struct packed {
    logic capture;
    logic zeroRes;
  } ectStrobe_t;

  localparam int unsigned CR_VEC_BASE = 8;
endpackage

// File: rtl/ect_datapath.sv
module ect_datapath
  import ect_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ACC_W  = 64,
  parameter int IDX_W  = 6,
  parameter int CRI_W  = 7
) (
  input  logic                clk,
  input  logic                rstN,
  input  ectStrobe_t          strobe,
  input  logic [ACC_W-1:0]    elemResult,
  input  logic [1:0]          elemWidth,
  input  logic [IDX_W-1:0]    elemIdx,
  input  logic                satEn,
  input  logic                satSigned,
  input  logic [1:0]          crSel,
  input  logic                crInv,
  input  logic                destVec,
  input  logic                destFp,
  output logic                testPass,
  output logic [DATA_W-1:0]   resData,
  output logic [IDX_W-1:0]    resIdx,
  output logic [3:0]          crData,
  output logic [CRI_W-1:0]    crIdx
);
  int unsigned               wBits;
  logic        [ACC_W-1:0]   widthMask;
  logic        [ACC_W-1:0]   topBit;
  logic signed [ACC_W-1:0]   accS, sMax, sMin, uMax, clamped;
  logic        [ACC_W-1:0]   narrow;
  logic                      satHit, signBit, isZero;
  logic        [3:0]         crField;

  always_comb begin
    case (elemWidth)
      2'b01:   wBits = 8;
      2'b10:   wBits = 16;
      2'b11:   wBits = 32;
      default: wBits = DATA_W;
    endcase
    widthMask = {ACC_W{1'b1}} >> (ACC_W - wBits);
    topBit    = widthMask ^ (widthMask >> 1);
    accS      = elemResult;
    uMax      = widthMask;
    sMax      = widthMask >> 1;
    sMin      = ~sMax;
    clamped   = accS;
    satHit    = 1'b0;
    if (satEn && satSigned) begin
      if (accS > sMax) begin
        clamped = sMax;  satHit = 1'b1;
      end else if (accS < sMin) begin
        clamped = sMin;  satHit = 1'b1;
      end
    end else if (satEn) begin
      if (accS < 0) begin
        clamped = '0;    satHit = 1'b1;
      end else if (accS > uMax) begin
        clamped = uMax;  satHit = 1'b1;
      end
    end
    narrow  = clamped & widthMask;
    signBit = |(narrow & topBit);
    isZero  = (narrow == '0);
    crField = {signBit, ~signBit & ~isZero, isZero, satHit & satEn};
    case (crSel)
      2'd0:    testPass = crField[3] ^ crInv;
      2'd1:    testPass = crField[2] ^ crInv;
      2'd2:    testPass = crField[1] ^ crInv;
      default: testPass = crField[0] ^ crInv;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resData <= '0;
      resIdx  <= '0;
      crData  <= '0;
      crIdx   <= '0;
    end else if (strobe.capture) begin
      resData <= strobe.zeroRes ? '0 : narrow[DATA_W-1:0];
      resIdx  <= elemIdx;
      crData  <= crField;
      if (destVec) crIdx <= CRI_W'(CR_VEC_BASE) + CRI_W'(elemIdx);
      else         crIdx <= destFp ? CRI_W'(1) : '0;
    end
  end

  // R3: one and only one of LT/GT/EQ after a capture
  p_cmp_excl_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> ($countones(crData[3:1]) == 1));
endmodule

// File: rtl/ect_control.sv
module ect_control
  import ect_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             opStart,
  input  logic [1:0]       mode,
  input  logic             ldstFf,
  input  logic             zeroEn,
  input  logic             recEn,
  input  logic [IDX_W:0]   cfgVl,
  input  logic             elemValid,
  input  logic [IDX_W-1:0] elemIdx,
  input  logic             elemMask,
  input  logic             elemFault,
  input  logic             elemLast,
  input  logic             testPass,
  output ectStrobe_t       strobe,
  output logic             resWe,
  output logic             crWe,
  output logic             done,
  output logic             trap,
  output logic [IDX_W:0]   vlOut
);
  logic halted;
  logic act, enabled, ffFail, trapHit, keep, predOk, stop;
  logic nxtResWe, nxtCrWe;
  logic [IDX_W:0] nxtVl;

  always_comb begin
    act      = elemValid & ~halted;
    enabled  = act & elemMask;
    ffFail   = enabled & (mode == MODE_FFIRST) &
               (ldstFf ? elemFault : ~testPass);
    trapHit  = ffFail & ldstFf & (elemIdx == '0);
    keep     = act & ~ffFail;
    predOk   = (mode == MODE_PRED) ? testPass : 1'b1;
    nxtResWe = keep & ((elemMask & predOk) | zeroEn);
    nxtCrWe  = keep & elemMask & recEn;
    stop     = ffFail | (act & elemLast);
    nxtVl    = (ffFail && !trapHit) ? {1'b0, elemIdx} : cfgVl;
    strobe.capture = act;
    strobe.zeroRes = ~(elemMask & predOk);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      halted <= 1'b0;
      resWe  <= 1'b0;
      crWe   <= 1'b0;
      done   <= 1'b0;
      trap   <= 1'b0;
      vlOut  <= '0;
    end else begin
      resWe <= nxtResWe;
      crWe  <= nxtCrWe;
      done  <= stop;
      trap  <= trapHit;
      if (stop) vlOut <= nxtVl;
      if (stop)         halted <= 1'b1;
      else if (opStart) halted <= 1'b0;
    end
  end

  // R11: the cycle after done is silent
  p_quiet_after_stop_r11: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!resWe && !crWe && !done));
  // R10: a reported fault always ends the operation
  p_trap_ends_op_r10: assert property (@(posedge clk) disable iff (!rstN)
    trap |-> done);
  // R9: truncation never lengthens the vector
  p_vl_bound_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (vlOut <= cfgVl));
endmodule

// File: rtl/elem_cond_trunc.sv
module elem_cond_trunc
  import ect_pkg::*;
#(
  parameter  int DATA_W = 32,
  parameter  int IDX_W  = 6,
  localparam int ACC_W  = 2 * DATA_W,
  localparam int CRI_W  = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opStart,
  input  logic [1:0]        cfgMode,
  input  logic              cfgZero,
  input  logic              cfgRec,
  input  logic              cfgSatSigned,
  input  logic [1:0]        cfgCrSel,
  input  logic              cfgCrInv,
  input  logic              cfgLdst,
  input  logic              cfgDestVec,
  input  logic              cfgDestFp,
  input  logic [IDX_W:0]    cfgVl,
  input  logic              elemValid,
  input  logic [IDX_W-1:0]  elemIdx,
  input  logic [1:0]        elemWidth,
  input  logic [ACC_W-1:0]  elemResult,
  input  logic              elemMask,
  input  logic              elemFault,
  input  logic              elemLast,
  output logic              resWe,
  output logic [IDX_W-1:0]  resIdx,
  output logic [DATA_W-1:0] resData,
  output logic              crWe,
  output logic [CRI_W-1:0]  crIdx,
  output logic [3:0]        crData,
  output logic              done,
  output logic              trap,
  output logic [IDX_W:0]    vlOut
);
  ectStrobe_t strobe;
  logic       testPass;
  logic       satEn;

  assign satEn = (cfgMode == MODE_SAT);

  ect_control #(.IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .opStart(opStart), .mode(cfgMode),
    .ldstFf(cfgLdst), .zeroEn(cfgZero), .recEn(cfgRec), .cfgVl(cfgVl),
    .elemValid(elemValid), .elemIdx(elemIdx), .elemMask(elemMask),
    .elemFault(elemFault), .elemLast(elemLast), .testPass(testPass),
    .strobe(strobe), .resWe(resWe), .crWe(crWe), .done(done),
    .trap(trap), .vlOut(vlOut)
  );

  ect_datapath #(.DATA_W(DATA_W), .ACC_W(ACC_W), .IDX_W(IDX_W), .CRI_W(CRI_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .elemResult(elemResult),
    .elemWidth(elemWidth), .elemIdx(elemIdx), .satEn(satEn),
    .satSigned(cfgSatSigned), .crSel(cfgCrSel), .crInv(cfgCrInv),
    .destVec(cfgDestVec), .destFp(cfgDestFp), .testPass(testPass),
    .resData(resData), .resIdx(resIdx), .crData(crData), .crIdx(crIdx)
  );

  // R2: a masked-out element can only ever write zero
  p_zero_data_r2: assert property (@(posedge clk) disable iff (!rstN)
    (resWe && $past(elemValid && !elemMask)) |-> (resData == '0));
  // R3: overflow bit stays clear outside saturate mode
  p_ov_only_sat_r3: assert property (@(posedge clk) disable iff (!rstN)
    (crWe && $past(cfgMode != MODE_SAT)) |-> !crData[0]);
endmodule

// File: tb/elem_cond_trunc_bench.sv
module elem_cond_trunc_bench;
  localparam int DATA_W = 32;
  localparam int IDX_W  = 6;

  logic clk = 0, rstN = 0, opStart = 0;
  logic [1:0] cfgMode = 0, cfgCrSel = 0, elemWidth = 0;
  logic cfgZero = 0, cfgRec = 0, cfgSatSigned = 0, cfgCrInv = 0, cfgLdst = 0;
  logic cfgDestVec = 1, cfgDestFp = 0;
  logic [IDX_W:0] cfgVl = 0;
  logic elemValid = 0, elemMask = 0, elemFault = 0, elemLast = 0;
  logic [IDX_W-1:0] elemIdx = 0;
  logic [2*DATA_W-1:0] elemResult = 0;
  logic resWe, crWe, done, trap;
  logic [IDX_W-1:0] resIdx;
  logic [DATA_W-1:0] resData;
  logic [IDX_W:0] crIdx, vlOut;
  logic [3:0] crData;

  int nChecks = 0, nFail = 0;

  always #10ns clk = ~clk;

  elem_cond_trunc #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_elem_cond_trunc (
    .clk(clk), .rstN(rstN), .opStart(opStart), .cfgMode(cfgMode),
    .cfgZero(cfgZero), .cfgRec(cfgRec), .cfgSatSigned(cfgSatSigned),
    .cfgCrSel(cfgCrSel), .cfgCrInv(cfgCrInv), .cfgLdst(cfgLdst),
    .cfgDestVec(cfgDestVec), .cfgDestFp(cfgDestFp), .cfgVl(cfgVl),
    .elemValid(elemValid), .elemIdx(elemIdx), .elemWidth(elemWidth),
    .elemResult(elemResult), .elemMask(elemMask), .elemFault(elemFault),
    .elemLast(elemLast), .resWe(resWe), .resIdx(resIdx), .resData(resData),
    .crWe(crWe), .crIdx(crIdx), .crData(crData), .done(done), .trap(trap),
    .vlOut(vlOut)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int wOf(input logic [1:0] c);
    case (c)
      2'b01:   return 8;
      2'b10:   return 16;
      2'b11:   return 32;
      default: return DATA_W;
    endcase
  endfunction

  // expected narrowed value and clamp flag
  task automatic model(input longint acc, input int w, input bit sat, input bit sgn,
                       output longint v, output bit hit);
    longint umax = (longint'(1) << w) - 1;
    longint smax = (longint'(1) << (w - 1)) - 1;
    longint smin = -(longint'(1) << (w - 1));
    v = acc; hit = 0;
    if (sat && sgn) begin
      if (acc > smax) begin v = smax; hit = 1; end
      else if (acc < smin) begin v = smin; hit = 1; end
    end else if (sat) begin
      if (acc < 0) begin v = 0; hit = 1; end
      else if (acc > umax) begin v = umax; hit = 1; end
    end
    v = v & umax;
  endtask

  function automatic logic [3:0] crOf(input longint v, input int w, input bit ov);
    bit s = v[w-1];
    bit z = (v == 0);
    return {s, !s && !z, z, ov};
  endfunction

  // present one element at a falling edge, sample at the next falling edge
  task automatic elem(input int idx, input logic [1:0] wc, input longint val,
                      input bit mask, input bit fault, input bit last);
    @(negedge clk);
    elemValid = 1; elemIdx = IDX_W'(idx); elemWidth = wc;
    elemResult = val; elemMask = mask; elemFault = fault; elemLast = last;
    @(negedge clk);
    elemValid = 0; elemLast = 0; elemFault = 0;
  endtask

  task automatic startOp;
    @(negedge clk); opStart = 1;
    @(negedge clk); opStart = 0;
  endtask

  longint vals[16] = '{-70000, -300, -129, -128, -1, 0, 1, 127, 128, 255, 256,
                       70000, 32768, -32769, 64'sd5000000000, -64'sd5000000000};

  initial begin
    #(20ns * 150000);
    nFail++; nChecks++;
    $display("FAIL R13 watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    longint v; bit hit; int n;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk("R13 reset resWe", resWe, 0);
    chk("R13 reset crWe", crWe, 0);
    chk("R13 reset done", done, 0);
    chk("R13 reset trap", trap, 0);
    chk("R13 reset vlOut", vlOut, 0);

    // sweep: plain and saturate, both signs, all widths
    cfgRec = 1; cfgDestVec = 1; n = 0;
    for (int m = 0; m < 2; m++)
      for (int sg = 0; sg < 2; sg++)
        for (int wc = 0; wc < 4; wc++)
          for (int k = 0; k < 16; k++) begin
            cfgMode = (m == 1) ? 2'b10 : 2'b00;
            cfgSatSigned = sg[0];
            model(vals[k], wOf(wc[1:0]), m == 1, sg[0], v, hit);
            elem(n % 64, wc[1:0], vals[k], 1, 0, 0);
            chk("R1 resWe", resWe, 1);
            chk(m == 1 ? (sg ? "R6 signed clamp" : "R5 unsigned clamp") : "R1 wrap",
                resData, v);
            chk("R3 crWe", crWe, 1);
            chk(m == 1 ? "R6 cr overflow" : "R3 cr field", crData,
                crOf(v, wOf(wc[1:0]), hit && m == 1));
            chk("R4 vector crIdx", crIdx, 8 + (n % 64));
            chk("R1 resIdx", resIdx, n % 64);
            n++;
          end
    @(negedge clk);
    chk("R13 one-cycle strobe", resWe, 0);

    // R4 scalar indices
    cfgMode = 2'b00; cfgDestVec = 0;
    for (int fp = 0; fp < 2; fp++) begin
      cfgDestFp = fp[0];
      elem(5, 2'b01, 3, 1, 0, 0);
      chk("R4 scalar crIdx", crIdx, fp);
    end
    cfgDestVec = 1;

    // R2 masked-out elements
    for (int z = 0; z < 2; z++) begin
      cfgZero = z[0];
      elem(3, 2'b01, 77, 0, 0, 0);
      chk("R2 masked resWe", resWe, z);
      if (z == 1) chk("R2 zeroed data", resData, 0);
      chk("R2 masked crWe", crWe, 0);
    end

    // R7/R8 predicated result sweep
    cfgMode = 2'b11;
    for (int z = 0; z < 2; z++)
      for (int sel = 0; sel < 4; sel++)
        for (int inv = 0; inv < 2; inv++)
          for (int k = 0; k < 3; k++) begin
            longint val = (k == 0) ? -5 : (k == 1) ? 0 : 5;
            logic [3:0] cr;
            bit pass;
            cfgZero = z[0]; cfgCrSel = sel[1:0]; cfgCrInv = inv[0];
            model(val, 8, 0, 0, v, hit);
            cr = crOf(v, 8, 0);
            pass = cr[3 - sel] ^ inv[0];
            elem(k, 2'b01, val, 1, 0, 0);
            chk("R7 test gates resWe", resWe, pass | z[0]);
            if (resWe) chk("R8 pred data", resData, pass ? v : 0);
            chk("R8 cr written on fail", crWe, 1);
            chk("R8 cr data", crData, cr);
          end
    cfgZero = 0;

    // R9 condition-driven fail-on-first: pass when nonzero
    cfgMode = 2'b01; cfgLdst = 0; cfgCrSel = 2; cfgCrInv = 1; cfgVl = 4;
    startOp();
    elem(0, 2'b01, 3, 1, 0, 0);
    chk("R9 elem0 written", resWe, 1);
    chk("R9 elem0 no done", done, 0);
    elem(1, 2'b01, 7, 1, 0, 0);
    chk("R9 elem1 written", resWe, 1);
    elem(2, 2'b01, 0, 1, 0, 0);
    chk("R9 fail no write", resWe, 0);
    chk("R9 fail no cr", crWe, 0);
    chk("R9 done", done, 1);
    chk("R9 truncated vl", vlOut, 2);
    elem(3, 2'b01, 9, 1, 0, 1);
    chk("R11 ignored write", resWe, 0);
    chk("R11 no second done", done, 0);
    chk("R11 vl held", vlOut, 2);

    startOp();
    elem(0, 2'b01, 0, 1, 0, 0);
    chk("R9 zero length done", done, 1);
    chk("R9 zero length vl", vlOut, 0);

    // R10 load/store fail-on-first
    cfgLdst = 1;
    startOp();
    elem(0, 2'b01, 4, 1, 1, 0);
    chk("R10 trap on elem0", trap, 1);
    chk("R10 done on elem0", done, 1);
    chk("R10 vl kept", vlOut, 4);
    chk("R10 no write", resWe, 0);
    startOp();
    elem(0, 2'b01, 0, 1, 0, 0);
    chk("R10 test not applied", resWe, 1);
    elem(1, 2'b01, 2, 1, 0, 0);
    elem(2, 2'b01, 2, 1, 1, 0);
    chk("R10 later fault no trap", trap, 0);
    chk("R10 later fault done", done, 1);
    chk("R10 later fault vl", vlOut, 2);
    chk("R10 later fault no write", resWe, 0);
    cfgLdst = 0;

    // R12 normal completion
    cfgMode = 2'b00; cfgVl = 3;
    startOp();
    elem(0, 2'b10, 1, 1, 0, 0);
    elem(1, 2'b10, 2, 1, 0, 0);
    chk("R12 no early done", done, 0);
    elem(2, 2'b10, 3, 1, 0, 1);
    chk("R12 done on last", done, 1);
    chk("R12 vl full", vlOut, 3);
    chk("R12 last written", resWe, 1);

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule